// File: doc/BRIEF.md
# Non-Maskable Interrupt Enable Controller

This block is the interrupt-mask slice of a CPU condition-code register. It gates a non-maskable interrupt input through a mask bit that hardware alone can set. The bit comes up set after reset, so the non-maskable source stays blocked until software has prepared a stack and cleared the bit. A software load of the register can clear the mask but can never set it. Accepting the non-maskable interrupt sets the mask again, so a bouncing input cannot nest.

The block also carries the ordinary maskable interrupt bit, which loads like any other register bit. It contains two-flop input synchronisers, the 8-bit register and a small sequencer stub. The stub turns a pending request into a one-cycle acknowledge after a fixed wait. On each acknowledge the block captures the register image that the CPU would push onto its stack. The same write port serves both the transfer-to-register instruction and the register restore at the end of an interrupt handler.

Top module: `nmi_mask_ctrl`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, `ccr_o` is 8'h50: the non-maskable mask is bit 6 and the maskable mask is bit 4, both at 1, and every other bit is 0. In the same state both pending outputs, both acknowledges and `stack_valid_o` are 0. An asynchronous reset overrides a write in the same cycle.
- R2: A write (`ccr_we_i`=1) with `ccr_wdata_i[6]`=0 clears bit 6. On any write, every bit other than bit 6 takes the written data at the next rising edge.
- R3: A write with `ccr_wdata_i[6]`=1 leaves bit 6 unchanged: a set mask stays set and a clear mask stays clear. With `ccr_we_i`=0 the register holds.
- R4: `xirq_pend_o` is the input `xirq_i`, passed through two flip-flops, ANDed with bit 6 being 0. After `xirq_i` rises with the mask clear, `xirq_pend_o` goes high after the second rising edge and not after the first.
- R5: The stub raises `ack_xirq_o` for exactly one cycle. It does so ACK_LAT+1 rising edges after `xirq_pend_o` rises, with the default ACK_LAT of 2.
- R6: At the rising edge that ends an acknowledge, `stack_ccr_o` captures the register value from the acknowledge cycle, with bit 6 at 0. `stack_valid_o` is high for that one cycle, and bit 6 of the live register becomes 1.
- R7: If an acknowledge and a write with bit 6 equal to 0 fall in the same cycle, bit 6 ends at 1.
- R8: `irq_pend_o` is the synchronised `irq_i` ANDed with bit 4 being 0. A non-maskable request pending in the same cycle is acknowledged first. `ack_irq_o` sets bit 4, and its stacked image has bit 4 at 0.
- R9: While bit 6 is 1, a held `xirq_i` produces neither `xirq_pend_o` nor `ack_xirq_o`. While bit 4 is 1, a held `irq_i` produces no `irq_pend_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xirq_i | input | 1 | Non-maskable request, asynchronous, active high |
| irq_i | input | 1 | Maskable request, asynchronous, active high |
| ccr_we_i | input | 1 | Register write strobe (transfer or restore) |
| ccr_wdata_i | input | 8 | Register write data |
| xirq_pend_o | output | 1 | Non-maskable request pending |
| irq_pend_o | output | 1 | Maskable request pending |
| ack_xirq_o | output | 1 | One-cycle non-maskable acknowledge |
| ack_irq_o | output | 1 | One-cycle maskable acknowledge |
| stack_valid_o | output | 1 | Stack image captured this cycle |
| stack_ccr_o | output | 8 | Register image to push |
| ccr_o | output | 8 | Live register value |
| x_mask_o | output | 1 | Non-maskable mask (bit 6) |
| i_mask_o | output | 1 | Maskable mask (bit 4) |

## Verification
The assertions check the following on every cycle. Software writes never set the non-maskable mask. A write with bit 6 clear clears it unless an acknowledge competes in that cycle. Every acknowledge sets the mask and lasts one cycle. The two acknowledges are never high together, and each stacked non-maskable image has bit 6 clear. Only the bench's scenarios can show the exact two-flop latency, the acknowledge wait, the data loaded into the other bits, the order of two simultaneous requests, and reset winning over a concurrent write.

// File: rtl/nmi_mask_pkg.sv
package nmi_mask_pkg;
  localparam int unsigned CCR_W  = 8;
  localparam int unsigned X_BIT  = 6;
  localparam int unsigned I_BIT  = 4;
  localparam logic [CCR_W-1:0] CCR_RST = (CCR_W'(1) << X_BIT) | (CCR_W'(1) << I_BIT);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } stub_st_e;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/nmi_ccr_reg.sv
module nmi_ccr_reg
  import nmi_mask_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CCR_W-1:0] wdata_i,
  input  logic             set_x_i,
  input  logic             set_i_i,
  output logic [CCR_W-1:0] ccr_o
);
  for (genvar b = 0; b < CCR_W; b++) begin : g_bit
    if (b == X_BIT) begin : g_x
      // set-reset latch: set dominates, software can only clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 ccr_o[b] <= CCR_RST[b];
        else if (set_x_i)            ccr_o[b] <= 1'b1;
        else if (we_i && !wdata_i[b]) ccr_o[b] <= 1'b0;
      end
    end else if (b == I_BIT) begin : g_i
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      ccr_o[b] <= CCR_RST[b];
        else if (set_i_i) ccr_o[b] <= 1'b1;
        else if (we_i)    ccr_o[b] <= wdata_i[b];
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   ccr_o[b] <= CCR_RST[b];
        else if (we_i) ccr_o[b] <= wdata_i[b];
      end
    end
  end
endmodule

// File: rtl/nmi_seq_stub.sv
module nmi_seq_stub
  import nmi_mask_pkg::*;
#(
  parameter int unsigned ACK_LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xpend_i,
  input  logic ipend_i,
  output logic ack_x_o,
  output logic ack_i_o
);
  localparam int unsigned CNT_W = (ACK_LAT > 1) ? $clog2(ACK_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_LAT - 1);

  stub_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             any_pend;

  assign any_pend = xpend_i | ipend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (any_pend) begin
          st_q  <= ST_WAIT;
          cnt_q <= '0;
        end
        ST_WAIT: begin
          if (!any_pend)             st_q  <= ST_IDLE;
          else if (cnt_q == CNT_LAST) st_q  <= ST_ACK;
          else                       cnt_q <= cnt_q + 1'b1;
        end
        ST_ACK:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // non-maskable source has priority
  assign ack_x_o = (st_q == ST_ACK) && xpend_i;
  assign ack_i_o = (st_q == ST_ACK) && ipend_i && !xpend_i;
endmodule

// File: rtl/nmi_stack_img.sv
module nmi_stack_img
  import nmi_mask_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  input  logic [CCR_W-1:0] ccr_i,
  output logic             valid_o,
  output logic [CCR_W-1:0] img_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      img_o   <= '0;
    end else begin
      valid_o <= ack_i;
      if (ack_i) img_o <= ccr_i;
    end
  end
endmodule

// File: rtl/nmi_mask_ctrl.sv
module nmi_mask_ctrl
  import nmi_mask_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ACK_LAT     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xirq_i,
  input  logic             irq_i,
  input  logic             ccr_we_i,
  input  logic [CCR_W-1:0] ccr_wdata_i,
  output logic             xirq_pend_o,
  output logic             irq_pend_o,
  output logic             ack_xirq_o,
  output logic             ack_irq_o,
  output logic             stack_valid_o,
  output logic [CCR_W-1:0] stack_ccr_o,
  output logic [CCR_W-1:0] ccr_o,
  output logic             x_mask_o,
  output logic             i_mask_o
);
  logic [1:0]       req_s;
  logic [CCR_W-1:0] ccr_q;

  nmi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({irq_i, xirq_i}),
    .q_o   (req_s)
  );

  nmi_ccr_reg u_ccr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ccr_we_i),
    .wdata_i(ccr_wdata_i),
    .set_x_i(ack_xirq_o),
    .set_i_i(ack_irq_o),
    .ccr_o  (ccr_q)
  );

  assign xirq_pend_o = req_s[0] && !ccr_q[X_BIT];
  assign irq_pend_o  = req_s[1] && !ccr_q[I_BIT];

  nmi_seq_stub #(.ACK_LAT(ACK_LAT)) u_stub (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .xpend_i(xirq_pend_o),
    .ipend_i(irq_pend_o),
    .ack_x_o(ack_xirq_o),
    .ack_i_o(ack_irq_o)
  );

  nmi_stack_img u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (ack_xirq_o | ack_irq_o),
    .ccr_i  (ccr_q),
    .valid_o(stack_valid_o),
    .img_o  (stack_ccr_o)
  );

  assign ccr_o    = ccr_q;
  assign x_mask_o = ccr_q[X_BIT];
  assign i_mask_o = ccr_q[I_BIT];
endmodule

// File: rtl/nmi_mask_ctrl_chk.sv
module nmi_mask_ctrl_chk
  import nmi_mask_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             xirq_i,
  input logic             irq_i,
  input logic             ccr_we_i,
  input logic [CCR_W-1:0] ccr_wdata_i,
  input logic             xirq_pend_o,
  input logic             irq_pend_o,
  input logic             ack_xirq_o,
  input logic             ack_irq_o,
  input logic             stack_valid_o,
  input logic [CCR_W-1:0] stack_ccr_o,
  input logic [CCR_W-1:0] ccr_o,
  input logic             x_mask_o,
  input logic             i_mask_o
);
  AST_WRITE_CLEARS_X: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ccr_we_i && !ccr_wdata_i[X_BIT] && !ack_xirq_o) |=> !x_mask_o); // R2

  AST_NO_SW_SET_X: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!x_mask_o && !ack_xirq_o) |=> !x_mask_o); // R3

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_xirq_o |=> !ack_xirq_o); // R5

  AST_ACK_SETS_X: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_xirq_o |=> (x_mask_o && stack_valid_o)); // R6

  AST_STACK_X_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_xirq_o |=> !stack_ccr_o[X_BIT]); // R6

  AST_ACK_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_xirq_o && ack_irq_o)); // R8

  AST_IACK_SETS_I: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_irq_o |=> (i_mask_o && !stack_ccr_o[I_BIT])); // R8

  AST_MASK_BLOCKS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_mask_o |-> (!ack_xirq_o && !xirq_pend_o)); // R9
endmodule

bind nmi_mask_ctrl nmi_mask_ctrl_chk u_chk (.*);

// File: tb/nmi_mask_ctrl_test.sv
`timescale 1ns/1ps
module nmi_mask_ctrl_test;
  localparam int unsigned ACK_LAT = 2;
  localparam int NVEC = 8;
  // {we, wdata, expected ccr after the edge}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 8'hFF, 8'hFF},
    {1'b1, 8'h00, 8'h00},
    {1'b1, 8'h40, 8'h00},
    {1'b1, 8'hD5, 8'h95},
    {1'b1, 8'h2A, 8'h2A},
    {1'b0, 8'hFF, 8'h2A},
    {1'b1, 8'h10, 8'h10},
    {1'b1, 8'h5F, 8'h1F}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       xirq_i = 1'b0, irq_i = 1'b0, ccr_we_i = 1'b0;
  logic [7:0] ccr_wdata_i = 8'h00;
  logic       xirq_pend_o, irq_pend_o, ack_xirq_o, ack_irq_o, stack_valid_o;
  logic [7:0] stack_ccr_o, ccr_o;
  logic       x_mask_o, i_mask_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  nmi_mask_ctrl #(.ACK_LAT(ACK_LAT)) uut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    ccr_we_i = 1'b1; ccr_wdata_i = d;
    @(negedge clk_i);
    ccr_we_i = 1'b0;
  endtask

  task automatic wait_ack(input bit kind_irq, output int cyc);
    cyc = 0;
    while ((kind_irq ? ack_irq_o : ack_xirq_o) !== 1'b1 && cyc < 50) begin
      @(negedge clk_i); cyc++;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int c;
    @(negedge clk_i);
    chk("R1 reset ccr", ccr_o, 8'h50);
    chk("R1 reset outputs", {3'b0, xirq_pend_o, irq_pend_o, ack_xirq_o, ack_irq_o, stack_valid_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", ccr_o, 8'h50);

    // vector table: R2 / R3 load behaviour
    for (int k = 0; k < NVEC; k++) begin
      ccr_we_i = VEC[k][16]; ccr_wdata_i = VEC[k][15:8];
      @(negedge clk_i);
      ccr_we_i = 1'b0;
      chk($sformatf("R2/R3 vector %0d", k), ccr_o, VEC[k][7:0]);
    end

    // R4/R5/R6: ccr = 8'h1F, X clear
    xirq_i = 1'b1;
    @(negedge clk_i);
    chk("R4 no pend after 1 edge", {7'b0, xirq_pend_o}, 8'h00);
    @(negedge clk_i);
    chk("R4 pend after 2 edges", {7'b0, xirq_pend_o}, 8'h01);
    for (int k = 0; k < ACK_LAT; k++) begin
      @(negedge clk_i);
      chk("R5 no early ack", {7'b0, ack_xirq_o}, 8'h00);
    end
    @(negedge clk_i);
    chk("R5 ack timing", {7'b0, ack_xirq_o}, 8'h01);
    @(negedge clk_i);
    chk("R5 ack one cycle", {7'b0, ack_xirq_o}, 8'h00);
    chk("R6 stack valid", {7'b0, stack_valid_o}, 8'h01);
    chk("R6 stacked image", stack_ccr_o, 8'h1F);
    chk("R6 live ccr X set", ccr_o, 8'h5F);
    @(negedge clk_i);
    chk("R6 valid one cycle", {7'b0, stack_valid_o}, 8'h00);

    // R9: masks set, inputs held
    irq_i = 1'b1;
    c = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk_i);
      if (xirq_pend_o || ack_xirq_o || irq_pend_o) c++;
    end
    chk("R9 masked requests ignored", 8'(c), 8'h00);
    irq_i = 1'b0;
    repeat (3) @(negedge clk_i);

    // R7: ack and clearing write in the same cycle
    wr(8'h00);
    chk("R2 clear X", ccr_o, 8'h00);
    wait_ack(1'b0, c);
    chk("R7 ack seen", {7'b0, ack_xirq_o}, 8'h01);
    ccr_we_i = 1'b1; ccr_wdata_i = 8'h00;
    @(negedge clk_i);
    ccr_we_i = 1'b0;
    chk("R7 set wins", ccr_o, 8'h40);
    chk("R7 stacked image", stack_ccr_o, 8'h00);

    // R8: both requests, X and I clear
    xirq_i = 1'b0;
    repeat (4) @(negedge clk_i);
    wr(8'h00);
    xirq_i = 1'b1; irq_i = 1'b1;
    wait_ack(1'b0, c);
    chk("R8 xirq first", {6'b0, ack_xirq_o, ack_irq_o}, 8'h02);
    @(negedge clk_i);
    chk("R8 irq still pending", {7'b0, irq_pend_o}, 8'h01);
    wait_ack(1'b1, c);
    chk("R8 irq ack", {7'b0, ack_irq_o}, 8'h01);
    @(negedge clk_i);
    chk("R8 irq stack image", stack_ccr_o, 8'h40);
    chk("R8 I set", ccr_o, 8'h50);
    xirq_i = 1'b0; irq_i = 1'b0;

    // R1: reset overrides concurrent write
    repeat (3) @(negedge clk_i);
    wr(8'h00);
    ccr_we_i = 1'b1; ccr_wdata_i = 8'h00;
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset", ccr_o, 8'h50);
    @(negedge clk_i);
    chk("R1 reset beats write", ccr_o, 8'h50);
    ccr_we_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after second reset", ccr_o, 8'h50);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule